// File: doc/BRIEF.md
# AXI4 Burst-Buffering Memory Front-End

This block is a complete AXI4 slave that sits between a system interconnect and a memory backend which works on whole transactions. Write addresses and read addresses go into separate queues. Write data beats are gathered until each burst is complete. Each transaction then goes to the backend as one wide request. The request carries the original transaction ID, the burst length and the offset of the address from a configurable base.

The backend may complete transactions in any order. A finished write comes back as an ID, and the block turns it into one B response. A finished read comes back as one wide block of data plus its ID and length. The block replays that block as consecutive R beats, with the matching ID, and marks the final beat with RLAST. The read side and the write side have separate backend request and accept signals, so neither side ever waits for the other.

Top module: `axi_burst_frontend`

## Requirements
- R1: While reset (active low) is asserted and after it is released, all queues are empty. s_bvalid, s_rvalid, m_wr_valid and m_rd_valid are low, and s_awready, s_wready and s_arready are high.
- R2: The AW queue holds 4 requests. With 4 requests queued, s_awready is low and no further address is taken. Queued requests reach the backend in arrival order, and none is lost.
- R3: m_wr_valid stays low until the W beat that carries s_wlast has been stored for the burst at the head of the queue. It rises at the first clock edge after that beat's handshake, provided an AW request is queued.
- R4: In the bulk write payload, beat k occupies data bits [k*DATA_W +: DATA_W] and strobe bits [k*DATA_W/8 +: DATA_W/8]. Bursts hold at most 16 beats, and the strobe lanes of beats past the burst length are zero.
- R5: m_wr_off and m_rd_off equal the AXI address minus BASE_ADDR.
- R6: m_wr_id and m_wr_len equal the AWID and AWLEN of the request. m_rd_id and m_rd_len equal the ARID and ARLEN.
- R7: A backend request leaves its queue only on a clock edge where its accept input is high. While valid is high and accept is low, the request and its fields hold steady.
- R8: A read request is presented to the backend even while a write request is stalled, and a write is presented even while a read is stalled.
- R9: A read completion of length L produces L+1 R beats. Beat k carries bits [k*DATA_W +: DATA_W] of the returned block, the completion ID and RRESP 2'b00. s_rlast is high on the last beat only. A beat holds steady while s_rready is low.
- R10: Each write completion produces exactly one B response, with the completion ID and BRESP 2'b00. The response holds until s_bready is high.
- R11: Responses leave in the order the backend completes them, not in request order.
- R12: The W queue holds 4 complete bursts, and s_wready is low while it is full. AXI ready outputs and backend valid outputs follow the queue state with no added wait cycle: a request is presented at the first edge after its address handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_awid | input | ID_W (4) | Write address ID |
| s_awaddr | input | ADDR_W (32) | Write address |
| s_awlen | input | 8 | Write burst length minus one |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W (32) | Write beat data |
| s_wstrb | input | DATA_W/8 (4) | Write beat byte strobes |
| s_wlast | input | 1 | Last beat of write burst |
| s_wvalid | input | 1 | Write beat valid |
| s_wready | output | 1 | Write beat ready |
| s_bid | output | ID_W (4) | Write response ID |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_arid | input | ID_W (4) | Read address ID |
| s_araddr | input | ADDR_W (32) | Read address |
| s_arlen | input | 8 | Read burst length minus one |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rid | output | ID_W (4) | Read beat ID |
| s_rdata | output | DATA_W (32) | Read beat data |
| s_rresp | output | 2 | Read response code |
| s_rlast | output | 1 | Last read beat |
| s_rvalid | output | 1 | Read beat valid |
| s_rready | input | 1 | Read beat ready |
| m_wr_valid | output | 1 | Backend write request valid |
| m_wr_accept | input | 1 | Backend can take a write request |
| m_wr_id | output | ID_W (4) | Write request ID |
| m_wr_off | output | ADDR_W (32) | Write offset from base |
| m_wr_len | output | 8 | Write burst length minus one |
| m_wr_data | output | MAX_BEATS*DATA_W (512) | Bulk write payload |
| m_wr_strb | output | MAX_BEATS*DATA_W/8 (64) | Bulk write strobes |
| m_rd_valid | output | 1 | Backend read request valid |
| m_rd_accept | input | 1 | Backend can take a read request |
| m_rd_id | output | ID_W (4) | Read request ID |
| m_rd_off | output | ADDR_W (32) | Read offset from base |
| m_rd_len | output | 8 | Read burst length minus one |
| m_wc_valid | input | 1 | Backend write completion valid |
| m_wc_ready | output | 1 | Write completion taken |
| m_wc_id | input | ID_W (4) | Write completion ID |
| m_rc_valid | input | 1 | Backend read completion valid |
| m_rc_ready | output | 1 | Read completion taken |
| m_rc_id | input | ID_W (4) | Read completion ID |
| m_rc_len | input | 8 | Read completion length minus one |
| m_rc_data | input | MAX_BEATS*DATA_W (512) | Read completion block |

## Verification
Every result is due exactly one rising edge after the handshake that causes it. A backend request appears one edge after its address handshake, or after the final W beat. The B response appears one edge after the write completion. The first R beat appears one edge after the read completion, and each later beat appears one edge after the previous beat was taken. The bench drives inputs and samples outputs on the falling edge, so each check reads the state that the single preceding rising edge produced. Stall cycles are inserted on purpose to show that nothing moves on an edge without its handshake.

// File: rtl/axi_burst_frontend.sv
module axi_burst_frontend #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 4,
  parameter int MAX_BEATS = 16,
  parameter int Q_DEPTH   = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h8000_0000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ID_W-1:0]               s_awid,
  input  logic [ADDR_W-1:0]             s_awaddr,
  input  logic [7:0]                    s_awlen,
  input  logic                          s_awvalid,
  output logic                          s_awready,
  input  logic [DATA_W-1:0]             s_wdata,
  input  logic [DATA_W/8-1:0]           s_wstrb,
  input  logic                          s_wlast,
  input  logic                          s_wvalid,
  output logic                          s_wready,
  output logic [ID_W-1:0]               s_bid,
  output logic [1:0]                    s_bresp,
  output logic                          s_bvalid,
  input  logic                          s_bready,
  input  logic [ID_W-1:0]               s_arid,
  input  logic [ADDR_W-1:0]             s_araddr,
  input  logic [7:0]                    s_arlen,
  input  logic                          s_arvalid,
  output logic                          s_arready,
  output logic [ID_W-1:0]               s_rid,
  output logic [DATA_W-1:0]             s_rdata,
  output logic [1:0]                    s_rresp,
  output logic                          s_rlast,
  output logic                          s_rvalid,
  input  logic                          s_rready,
  output logic                          m_wr_valid,
  input  logic                          m_wr_accept,
  output logic [ID_W-1:0]               m_wr_id,
  output logic [ADDR_W-1:0]             m_wr_off,
  output logic [7:0]                    m_wr_len,
  output logic [MAX_BEATS*DATA_W-1:0]   m_wr_data,
  output logic [MAX_BEATS*DATA_W/8-1:0] m_wr_strb,
  output logic                          m_rd_valid,
  input  logic                          m_rd_accept,
  output logic [ID_W-1:0]               m_rd_id,
  output logic [ADDR_W-1:0]             m_rd_off,
  output logic [7:0]                    m_rd_len,
  input  logic                          m_wc_valid,
  output logic                          m_wc_ready,
  input  logic [ID_W-1:0]               m_wc_id,
  input  logic                          m_rc_valid,
  output logic                          m_rc_ready,
  input  logic [ID_W-1:0]               m_rc_id,
  input  logic [7:0]                    m_rc_len,
  input  logic [MAX_BEATS*DATA_W-1:0]   m_rc_data
);

  localparam int STRB_W = DATA_W / 8;
  localparam int BLK_W  = MAX_BEATS * DATA_W;
  localparam int BLK_S  = MAX_BEATS * STRB_W;
  localparam int PTR_W  = (Q_DEPTH > 1) ? $clog2(Q_DEPTH) : 1;
  localparam int CNT_W  = $clog2(Q_DEPTH + 1);
  localparam int BEAT_W = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(Q_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // write address queue
  logic [ID_W-1:0]   aw_id_q  [Q_DEPTH];
  logic [ADDR_W-1:0] aw_off_q [Q_DEPTH];
  logic [7:0]        aw_len_q [Q_DEPTH];
  logic [PTR_W-1:0]  aw_wp, aw_rp;
  logic [CNT_W-1:0]  aw_cnt;
  logic              aw_push, wr_fire;

  // write burst queue (complete bursts only)
  logic [BLK_W-1:0]  wd_q [Q_DEPTH];
  logic [BLK_S-1:0]  ws_q [Q_DEPTH];
  logic [BLK_W-1:0]  wd_nx;
  logic [BLK_S-1:0]  ws_nx;
  logic [PTR_W-1:0]  w_wp, w_rp;
  logic [CNT_W-1:0]  w_cnt;
  logic [BEAT_W-1:0] w_beat;
  logic              w_push, w_done;

  // read address queue
  logic [ID_W-1:0]   ar_id_q  [Q_DEPTH];
  logic [ADDR_W-1:0] ar_off_q [Q_DEPTH];
  logic [7:0]        ar_len_q [Q_DEPTH];
  logic [PTR_W-1:0]  ar_wp, ar_rp;
  logic [CNT_W-1:0]  ar_cnt;
  logic              ar_push, rd_fire;

  // response side
  logic              r_busy, b_busy;
  logic [ID_W-1:0]   r_id;
  logic [7:0]        r_len, r_beat;
  logic [BLK_W-1:0]  r_blk;
  logic              rc_fire, r_take;

  assign s_awready = aw_cnt != CNT_W'(Q_DEPTH);
  assign s_wready  = w_cnt  != CNT_W'(Q_DEPTH);
  assign s_arready = ar_cnt != CNT_W'(Q_DEPTH);
  assign aw_push   = s_awvalid & s_awready;
  assign w_push    = s_wvalid & s_wready;
  assign w_done    = w_push & s_wlast;
  assign ar_push   = s_arvalid & s_arready;

  assign m_wr_valid = (aw_cnt != '0) && (w_cnt != '0);
  assign wr_fire    = m_wr_valid & m_wr_accept;
  assign m_wr_id    = aw_id_q[aw_rp];
  assign m_wr_off   = aw_off_q[aw_rp];
  assign m_wr_len   = aw_len_q[aw_rp];
  assign m_wr_data  = wd_q[w_rp];
  assign m_wr_strb  = ws_q[w_rp];

  assign m_rd_valid = ar_cnt != '0;
  assign rd_fire    = m_rd_valid & m_rd_accept;
  assign m_rd_id    = ar_id_q[ar_rp];
  assign m_rd_off   = ar_off_q[ar_rp];
  assign m_rd_len   = ar_len_q[ar_rp];

  assign m_rc_ready = !r_busy;
  assign rc_fire    = m_rc_valid & m_rc_ready;
  assign s_rvalid   = r_busy;
  assign s_rid      = r_id;
  assign s_rdata    = r_blk[r_beat[BEAT_W-1:0]*DATA_W +: DATA_W];
  assign s_rlast    = r_beat == r_len;
  assign s_rresp    = 2'b00;
  assign r_take     = s_rvalid & s_rready;

  assign m_wc_ready = !b_busy;
  assign s_bvalid   = b_busy;
  assign s_bresp    = 2'b00;

  always_comb begin
    wd_nx = (w_beat == '0) ? '0 : wd_q[w_wp];
    ws_nx = (w_beat == '0) ? '0 : ws_q[w_wp];
    wd_nx[w_beat*DATA_W +: DATA_W] = s_wdata;
    ws_nx[w_beat*STRB_W +: STRB_W] = s_wstrb;
  end

  always_ff @(posedge clk) begin
    if (aw_push) begin
      aw_id_q[aw_wp]  <= s_awid;
      aw_off_q[aw_wp] <= s_awaddr - BASE_ADDR;
      aw_len_q[aw_wp] <= s_awlen;
    end
    if (ar_push) begin
      ar_id_q[ar_wp]  <= s_arid;
      ar_off_q[ar_wp] <= s_araddr - BASE_ADDR;
      ar_len_q[ar_wp] <= s_arlen;
    end
    if (w_push) begin
      wd_q[w_wp] <= wd_nx;
      ws_q[w_wp] <= ws_nx;
    end
    if (rc_fire) r_blk <= m_rc_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_wp <= '0; aw_rp <= '0; aw_cnt <= '0;
      ar_wp <= '0; ar_rp <= '0; ar_cnt <= '0;
      w_wp  <= '0; w_rp  <= '0; w_cnt  <= '0; w_beat <= '0;
    end else begin
      if (aw_push) aw_wp <= ptr_inc(aw_wp);
      if (wr_fire) aw_rp <= ptr_inc(aw_rp);
      aw_cnt <= aw_cnt + CNT_W'(aw_push) - CNT_W'(wr_fire);
      if (ar_push) ar_wp <= ptr_inc(ar_wp);
      if (rd_fire) ar_rp <= ptr_inc(ar_rp);
      ar_cnt <= ar_cnt + CNT_W'(ar_push) - CNT_W'(rd_fire);
      if (w_push) w_beat <= s_wlast ? '0 : w_beat + 1'b1;
      if (w_done) w_wp <= ptr_inc(w_wp);
      if (wr_fire) w_rp <= ptr_inc(w_rp);
      w_cnt <= w_cnt + CNT_W'(w_done) - CNT_W'(wr_fire);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_busy <= 1'b0; r_id <= '0; r_len <= '0; r_beat <= '0;
      b_busy <= 1'b0; s_bid <= '0;
    end else begin
      if (rc_fire) begin
        r_busy <= 1'b1;
        r_id   <= m_rc_id;
        r_len  <= m_rc_len;
        r_beat <= '0;
      end else if (r_take) begin
        if (s_rlast) r_busy <= 1'b0;
        else         r_beat <= r_beat + 1'b1;
      end
      if (m_wc_valid && m_wc_ready) begin
        b_busy <= 1'b1;
        s_bid  <= m_wc_id;
      end else if (s_bvalid && s_bready) begin
        b_busy <= 1'b0;
      end
    end
  end

  AST_AW_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) aw_cnt <= CNT_W'(Q_DEPTH)); // R2
  AST_W_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) w_cnt <= CNT_W'(Q_DEPTH)); // R12
  AST_WBEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (w_push && !s_wlast) |-> (w_beat != BEAT_W'(MAX_BEATS - 1))); // R4
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (m_wr_valid && !m_wr_accept) |=> (m_wr_valid && $stable(m_wr_id) && $stable(m_wr_off) && $stable(m_wr_len))); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (m_rd_valid && !m_rd_accept) |=> (m_rd_valid && $stable(m_rd_id) && $stable(m_rd_off) && $stable(m_rd_len))); // R7
  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && $stable(s_rid) && $stable(s_rlast))); // R9
  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bid))); // R10

endmodule

// File: tb/axi_burst_frontend_tb_top.sv
module axi_burst_frontend_tb_top;
  localparam int AW = 32, DW = 32, IW = 4, MB = 16, SW = DW / 8;
  localparam logic [31:0] BASE = 32'h8000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [IW-1:0] s_awid = '0, s_arid = '0, s_bid, s_rid, m_wr_id, m_rd_id, m_wc_id = '0, m_rc_id = '0;
  logic [AW-1:0] s_awaddr = '0, s_araddr = '0, m_wr_off, m_rd_off;
  logic [7:0] s_awlen = '0, s_arlen = '0, m_wr_len, m_rd_len, m_rc_len = '0;
  logic s_awvalid = 0, s_awready, s_wlast = 0, s_wvalid = 0, s_wready, s_bvalid, s_bready = 0;
  logic s_arvalid = 0, s_arready, s_rlast, s_rvalid, s_rready = 0;
  logic [DW-1:0] s_wdata = '0, s_rdata;
  logic [SW-1:0] s_wstrb = '0;
  logic [1:0] s_bresp, s_rresp;
  logic m_wr_valid, m_wr_accept = 0, m_rd_valid, m_rd_accept = 0;
  logic m_wc_valid = 0, m_wc_ready, m_rc_valid = 0, m_rc_ready;
  logic [MB*DW-1:0] m_wr_data, m_rc_data = '0;
  logic [MB*SW-1:0] m_wr_strb;

  axi_burst_frontend dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_awid(s_awid), .s_awaddr(s_awaddr), .s_awlen(s_awlen), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wlast(s_wlast), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bid(s_bid), .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_arid(s_arid), .s_araddr(s_araddr), .s_arlen(s_arlen), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rid(s_rid), .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rlast(s_rlast), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .m_wr_valid(m_wr_valid), .m_wr_accept(m_wr_accept), .m_wr_id(m_wr_id), .m_wr_off(m_wr_off),
    .m_wr_len(m_wr_len), .m_wr_data(m_wr_data), .m_wr_strb(m_wr_strb),
    .m_rd_valid(m_rd_valid), .m_rd_accept(m_rd_accept), .m_rd_id(m_rd_id), .m_rd_off(m_rd_off), .m_rd_len(m_rd_len),
    .m_wc_valid(m_wc_valid), .m_wc_ready(m_wc_ready), .m_wc_id(m_wc_id),
    .m_rc_valid(m_rc_valid), .m_rc_ready(m_rc_ready), .m_rc_id(m_rc_id), .m_rc_len(m_rc_len), .m_rc_data(m_rc_data)
  );

  int checks = 0, errors = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wpat(input int id, input int k);
    return 32'h5A00_0000 + 32'(id) * 32'h0101_0000 + 32'(k) * 32'h0000_0111;
  endfunction
  function automatic logic [3:0] spat(input int id, input int k);
    return 4'((k * 5 + id + 3) % 16);
  endfunction
  function automatic logic [31:0] rpat(input int id, input int k);
    return 32'hC300_0000 ^ (32'(id) << 20) ^ (32'(k) * 32'h0001_0203);
  endfunction

  task automatic send_aw(input int id, input int len, input logic [31:0] addr);
    s_awvalid = 1; s_awid = 4'(id); s_awlen = 8'(len); s_awaddr = addr;
    chk("R12 awready with room", 64'(s_awready), 64'd1);
    @(negedge clk); s_awvalid = 0;
  endtask

  task automatic send_w(input int id, input int len, input bit probe);
    for (int k = 0; k <= len; k++) begin
      s_wvalid = 1; s_wdata = wpat(id, k); s_wstrb = spat(id, k); s_wlast = (k == len);
      if (probe) chk("R3 no write before last beat", 64'(m_wr_valid), 64'd0);
      @(negedge clk);
    end
    s_wvalid = 0; s_wlast = 0;
  endtask

  task automatic write_complete(input int id);
    m_wc_valid = 1; m_wc_id = 4'(id);
    chk("R10 completion taken", 64'(m_wc_ready), 64'd1);
    @(negedge clk); m_wc_valid = 0;
    chk("R10 bvalid", 64'(s_bvalid), 64'd1);
    chk("R10 bid", 64'(s_bid), 64'(id));
    chk("R10 bresp", 64'(s_bresp), 64'd0);
    @(negedge clk);
    chk("R10 b held under stall", 64'(s_bvalid), 64'd1);
    s_bready = 1; @(negedge clk); s_bready = 0;
    chk("R10 single response", 64'(s_bvalid), 64'd0);
  endtask

  task automatic read_complete(input int id, input int len);
    m_rc_valid = 1; m_rc_id = 4'(id); m_rc_len = 8'(len);
    for (int k = 0; k < MB; k++) m_rc_data[k*DW +: DW] = rpat(id, k);
    chk("R9 completion taken", 64'(m_rc_ready), 64'd1);
    @(negedge clk); m_rc_valid = 0;
    for (int k = 0; k <= len; k++) begin
      chk("R9 rvalid", 64'(s_rvalid), 64'd1);
      chk("R9 rid", 64'(s_rid), 64'(id));
      chk("R9 rdata", 64'(s_rdata), 64'(rpat(id, k)));
      chk("R9 rlast", 64'(s_rlast), 64'(k == len));
      chk("R9 rresp", 64'(s_rresp), 64'd0);
      if (k == 1) begin
        @(negedge clk);
        chk("R9 beat held under stall", 64'(s_rdata), 64'(rpat(id, k)));
      end
      s_rready = 1; @(negedge clk); s_rready = 0;
    end
    chk("R9 burst ends", 64'(s_rvalid), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 bvalid in reset", 64'(s_bvalid), 64'd0);
    chk("R1 rvalid in reset", 64'(s_rvalid), 64'd0);
    chk("R1 wr_valid in reset", 64'(m_wr_valid), 64'd0);
    chk("R1 rd_valid in reset", 64'(m_rd_valid), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 readies after reset", 64'({s_awready, s_wready, s_arready}), 64'h7);
    chk("R1 valids after reset", 64'({s_bvalid, s_rvalid, m_wr_valid, m_rd_valid}), 64'h0);

    // write sweep over every burst length
    for (int len = 0; len < MB; len++) begin
      int id = (len * 7 + 1) % 16;
      logic [31:0] addr = BASE + 32'(len) * 32'h140;
      send_aw(id, len, addr);
      send_w(id, len, 1'b1);
      chk("R3 write after last beat", 64'(m_wr_valid), 64'd1);
      chk("R6 write id", 64'(m_wr_id), 64'(id));
      chk("R6 write len", 64'(m_wr_len), 64'(len));
      chk("R5 write offset", 64'(m_wr_off), 64'(addr - BASE));
      for (int k = 0; k < MB; k++) begin
        if (k <= len) begin
          chk("R4 payload data", 64'(m_wr_data[k*DW +: DW]), 64'(wpat(id, k)));
          chk("R4 payload strobe", 64'(m_wr_strb[k*SW +: SW]), 64'(spat(id, k)));
        end else begin
          chk("R4 unused strobe zero", 64'(m_wr_strb[k*SW +: SW]), 64'd0);
        end
      end
      @(negedge clk);
      chk("R7 write held without accept", 64'({m_wr_valid, m_wr_id}), 64'({1'b1, 4'(id)}));
      m_wr_accept = 1; @(negedge clk); m_wr_accept = 0;
      chk("R7 write leaves on accept", 64'(m_wr_valid), 64'd0);
      write_complete(id);
    end

    // read sweep over every burst length
    for (int len = 0; len < MB; len++) begin
      int id = (len * 3 + 2) % 16;
      logic [31:0] addr = BASE + 32'h0010_0000 + 32'(len) * 32'h40;
      s_arvalid = 1; s_arid = 4'(id); s_arlen = 8'(len); s_araddr = addr;
      @(negedge clk); s_arvalid = 0;
      chk("R12 read presented next edge", 64'(m_rd_valid), 64'd1);
      chk("R6 read id", 64'(m_rd_id), 64'(id));
      chk("R6 read len", 64'(m_rd_len), 64'(len));
      chk("R5 read offset", 64'(m_rd_off), 64'(addr - BASE));
      @(negedge clk);
      chk("R7 read held without accept", 64'(m_rd_valid), 64'd1);
      m_rd_accept = 1; @(negedge clk); m_rd_accept = 0;
      chk("R7 read leaves on accept", 64'(m_rd_valid), 64'd0);
      read_complete(id, len);
    end

    // backpressure, ordering, independence
    for (int i = 1; i <= 4; i++) send_aw(i, 0, BASE + 32'(i) * 32'h10);
    chk("R2 awready low when full", 64'(s_awready), 64'd0);
    s_awvalid = 1; s_awid = 4'd5; s_awlen = 8'd0; s_awaddr = BASE + 32'h50;
    for (int i = 1; i <= 4; i++) send_w(i, 0, 1'b0);
    chk("R12 wready low when full", 64'(s_wready), 64'd0);
    chk("R2 fifth address still refused", 64'(s_awready), 64'd0);
    s_arvalid = 1; s_arid = 4'd9; s_arlen = 8'd0; s_araddr = BASE;
    @(negedge clk); s_arvalid = 0;
    chk("R8 read passes stalled write", 64'({m_rd_valid, m_wr_valid}), 64'h3);
    m_rd_accept = 1; @(negedge clk); m_rd_accept = 0;
    m_wr_accept = 1; @(negedge clk); m_wr_accept = 0;
    chk("R2 awready returns", 64'(s_awready), 64'd1);
    @(negedge clk); s_awvalid = 0;
    send_w(5, 0, 1'b0);
    m_wr_accept = 1;
    for (int i = 2; i <= 5; i++) begin
      chk("R2 queue order kept", 64'({m_wr_valid, m_wr_id}), 64'({1'b1, 4'(i)}));
      @(negedge clk);
    end
    m_wr_accept = 0;
    chk("R2 queue drained", 64'(m_wr_valid), 64'd0);
    write_complete(4);
    write_complete(2);
    chk("R11 later completion first", 64'(s_bid), 64'd2);
    read_complete(9, 0);
    read_complete(3, 2);
    chk("R11 read order follows backend", 64'(s_rvalid), 64'd0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule